// File: doc/BRIEF.md
# Logarithmic Companding Serial Data Path

This block connects a pair of 16-bit data registers, one for transmit and one for receive, to a single serial data line that carries one word per time slot. A two-bit word-length code selects the slot format. Three of the codes carry plain words of 8, 12 or 16 bits. In these modes the most significant bits of the transmit word are sent unchanged, and the received bits are placed left-justified in the receive register. The fourth code turns on logarithmic mode. In this mode every slot carries an 8-bit compressed code. The outgoing linear sample is compressed to an A-law or mu-law code, and the incoming code is expanded back to a left-justified linear value. One select input picks the law for both directions.

Slot timing comes from two inputs, both sampled in the system clock domain: a one-cycle bit-clock enable and a frame-sync qualifier. The word for the next slot is taken from the transmit register at the second-to-last bit clock of the current slot. In logarithmic mode, a missing word at that moment raises a sticky underrun flag, and the previous word is sent again. The flag is cleared by a status read followed by a transmit write.

Top module: `compand_serial_path`

## Requirements
- R1: Word-length codes select plain modes: 00 gives 8 bits, 10 gives 12 bits and 11 gives 16 bits. The top n bits of the transmit word go out MSB first. The received n bits are stored left-justified in rx_word, with zeros below them.
- R2: Code 01 selects logarithmic mode, which puts 8 bits on the line. With law_mu=0 (A-law), tx_word[15:3] is compressed as a 13-bit two's-complement value. The compression takes the segment as the position of the top set magnitude bit, takes 4 mantissa bits, and sets bit 7 to 1 for non-negative input. Bits 6..4 hold the segment and bits 3..0 the mantissa. The whole code is then XORed with 8'h55.
- R3: With law_mu=1 (mu-law), tx_word[15:2] is compressed as a 14-bit value. The magnitude is clipped to 8158, a bias of 33 is added, the segment and mantissa fields are formed, bit 7 is set for negative input, and the whole byte is inverted.
- R4: In A-law mode, a received code is expanded to a 13-bit signed value and stored in rx_word[15:3]. rx_word[2:0] reads zero.
- R5: In mu-law mode, a received code is expanded to a 14-bit signed value and stored in rx_word[15:2]. rx_word[1:0] reads zero.
- R6: A bit_tick with fsync=1 starts a slot and puts the word's MSB on sdo right after that edge. Each later bit_tick samples sdi and moves to the next bit. rx_word is updated at the edge of the tick that samples the last bit.
- R7: The next slot's word is captured at the second-to-last bit_tick of the current slot. A tx_wr completed before that tick goes out in the next slot. A later write goes out one slot later.
- R8: In logarithmic mode, if no tx_wr has occurred since the previous capture, underrun is set at the capture tick and the previous word is sent again.
- R9: Once set, underrun stays at 1 until a stat_rd is followed by a tx_wr. A tx_wr on its own, or a stat_rd on its own, leaves it at 1.
- R10: In the plain modes underrun is never set. A missing word still causes the previous word to be sent again.
- R11: After reset, sdo, rx_word and underrun are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_word | input | 16 | Left-justified transmit data |
| stat_rd | input | 1 | Status read strobe, first step of the underrun clear |
| law_mu | input | 1 | Law select: 0 A-law, 1 mu-law |
| wl_code | input | 2 | Word-length code |
| bit_tick | input | 1 | One-cycle bit-clock enable |
| fsync | input | 1 | Frame sync, qualified by bit_tick |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| rx_word | output | 16 | Left-justified receive data |
| underrun | output | 1 | Sticky transmit underrun flag |

## Verification
Every result is a single register stage behind the clock edge of the event that causes it. Each sdo bit is valid just after the bit_tick edge that starts or advances the slot. rx_word changes at the edge of the tick that samples the last bit. underrun rises at the edge of the second-to-last tick and falls at the edge of the clearing tx_wr. The bench drives each strobe for one cycle on a falling edge and reads the ports at the falling edge that follows the rising edge that consumed it. It records sdo and underrun after every tick, so the capture deadline is checked at the exact tick boundary.

// File: rtl/compand_pkg.sv
package compand_pkg;

    localparam int WORD_W    = 16;
    localparam int CODE_W    = 8;
    localparam int ALAW_W    = 13;
    localparam int MULAW_W   = 14;
    localparam int CNT_W     = $clog2(WORD_W + 1);
    localparam int ALAW_PAD  = WORD_W - ALAW_W;
    localparam int MULAW_PAD = WORD_W - MULAW_W;

    localparam logic [CODE_W-1:0]  ALAW_FLIP = 8'h55;
    localparam logic [MULAW_W-2:0] MU_BIAS   = 13'd33;
    localparam logic [MULAW_W-2:0] MU_CLIP   = 13'd8158;

    typedef enum logic [1:0] {
        WL_BYTE   = 2'b00,
        WL_LOG    = 2'b01,
        WL_TWELVE = 2'b10,
        WL_FULL   = 2'b11
    } wl_mode_e;

    typedef enum logic {
        LAW_A  = 1'b0,
        LAW_MU = 1'b1
    } law_e;

    typedef struct packed {
        logic       top;
        logic [2:0] seg;
        logic [3:0] mant;
    } lcode_t;

    function automatic logic [CNT_W-1:0] bits_per_slot(input wl_mode_e m);
        case (m)
            WL_TWELVE: return CNT_W'(12);
            WL_FULL:   return CNT_W'(16);
            default:   return CNT_W'(8);
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] alaw_compress(input logic [ALAW_W-1:0] x);
        logic              neg;
        logic [ALAW_W-2:0] mag;
        logic [2:0]        seg;
        lcode_t            c;
        neg = x[ALAW_W-1];
        mag = neg ? ~x[ALAW_W-2:0] : x[ALAW_W-2:0];
        seg = 3'd0;
        for (int b = 5; b < ALAW_W - 1; b++) begin
            if (mag[b]) seg = 3'(b - 4);
        end
        c.top  = ~neg;
        c.seg  = seg;
        c.mant = (seg == 3'd0) ? mag[4:1] : 4'(mag >> seg);
        return c ^ ALAW_FLIP;
    endfunction

    function automatic logic [ALAW_W-1:0] alaw_expand(input logic [CODE_W-1:0] code);
        lcode_t            c;
        logic [ALAW_W-2:0] mag;
        c = code ^ ALAW_FLIP;
        if (c.seg == 3'd0)
            mag = {7'd0, c.mant, 1'b1};
        else
            mag = {6'd0, 1'b1, c.mant, 1'b1} << (c.seg - 3'd1);
        return c.top ? {1'b0, mag} : (ALAW_W'(0) - {1'b0, mag});
    endfunction

    function automatic logic [CODE_W-1:0] mulaw_compress(input logic [MULAW_W-1:0] x);
        logic               neg;
        logic [MULAW_W-2:0] mag;
        logic [MULAW_W-2:0] biased;
        logic [2:0]         seg;
        lcode_t             c;
        neg = x[MULAW_W-1];
        mag = neg ? ~x[MULAW_W-2:0] : x[MULAW_W-2:0];
        if (mag > MU_CLIP) mag = MU_CLIP;
        biased = mag + MU_BIAS;
        seg = 3'd0;
        for (int b = 6; b < MULAW_W - 1; b++) begin
            if (biased[b]) seg = 3'(b - 5);
        end
        c.top  = neg;
        c.seg  = seg;
        c.mant = 4'(biased >> ({1'b0, seg} + 4'd1));
        return ~c;
    endfunction

    function automatic logic [MULAW_W-1:0] mulaw_expand(input logic [CODE_W-1:0] code);
        lcode_t             c;
        logic [MULAW_W-1:0] step;
        logic [MULAW_W-1:0] mag;
        c    = ~code;
        step = MULAW_W'({1'b1, c.mant, 1'b1}) << c.seg;
        mag  = step - MULAW_W'(MU_BIAS);
        return c.top ? (MULAW_W'(0) - mag) : mag;
    endfunction

endpackage

// File: rtl/compand_slot_timer.sv
module compand_slot_timer
    import compand_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  logic          fsync,
    input  logic [CW-1:0] nbits,
    output logic          load,
    output logic          shift,
    output logic          deadline,
    output logic          last
);

    logic          active;
    logic [CW-1:0] cnt;

    // R6: a frame-sync tick opens the slot, each later tick moves one bit
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (bit_tick) begin
            if (fsync) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                if (cnt == nbits - CW'(1)) active <= 1'b0;
                else                       cnt    <= cnt + CW'(1);
            end
        end
    end

    always_comb begin
        load     = bit_tick && fsync;
        shift    = bit_tick && active;
        deadline = shift && (cnt == nbits - CW'(2));   // R7: second-to-last tick
        last     = shift && (cnt == nbits - CW'(1));
    end

    p_ticks_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        $past(last) && !$past(fsync) |-> !shift || !active);

endmodule

// File: rtl/compand_tx_path.sv
module compand_tx_path
    import compand_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_word,
    input  logic         stat_rd,
    input  wl_mode_e     mode,
    input  law_e         law,
    input  logic         load,
    input  logic         shift,
    input  logic         deadline,
    output logic         sdo,
    output logic         underrun
);

    logic [W-1:0]      hold;
    logic              hold_full;
    logic [W-1:0]      next_word;
    logic [W-1:0]      tx_sr;
    logic              armed;
    logic [CODE_W-1:0] log_code;
    logic [W-1:0]      staged;
    logic              miss;

    // R2 / R3: the compressor runs on the held word at capture time
    always_comb begin
        if (law == LAW_MU) log_code = mulaw_compress(hold[W-1 -: MULAW_W]);
        else               log_code = alaw_compress(hold[W-1 -: ALAW_W]);
        staged = (mode == WL_LOG) ? {log_code, {(W-CODE_W){1'b0}}} : hold;
        miss   = deadline && !hold_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else begin
            if (tx_wr) begin
                hold      <= tx_word;
                hold_full <= 1'b1;
            end else if (deadline) begin
                hold_full <= 1'b0;
            end
        end
    end

    // R7 / R8 / R10: capture at the deadline, keep the old word on a miss
    always_ff @(posedge clk) begin
        if (rst)                        next_word <= '0;
        else if (deadline && hold_full) next_word <= staged;
    end

    // R1 / R6: MSB-first shifter, a load takes priority over a shift
    always_ff @(posedge clk) begin
        if (rst)        tx_sr <= '0;
        else if (load)  tx_sr <= next_word;
        else if (shift) tx_sr <= {tx_sr[W-2:0], 1'b0};
    end

    assign sdo = tx_sr[W-1];

    // R8 / R9: sticky flag with a two-step clear
    always_ff @(posedge clk) begin
        if (rst) begin
            underrun <= 1'b0;
            armed    <= 1'b0;
        end else if (miss && mode == WL_LOG) begin
            underrun <= 1'b1;
            armed    <= 1'b0;
        end else if (underrun && armed && tx_wr) begin
            underrun <= 1'b0;
            armed    <= 1'b0;
        end else if (underrun && stat_rd) begin
            armed    <= 1'b1;
        end
    end

    p_capture_on_deadline_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(next_word) |-> $past(deadline));

    p_resend_on_underrun_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $stable(next_word));

    p_clear_after_status_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(underrun) |-> $past(tx_wr) && $past(armed));

    p_rise_log_only_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(mode) == WL_LOG);

endmodule

// File: rtl/compand_rx_path.sv
module compand_rx_path
    import compand_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sdi,
    input  logic          shift,
    input  logic          last,
    input  wl_mode_e      mode,
    input  law_e          law,
    input  logic [CW-1:0] nbits,
    output logic [W-1:0]  rx_word
);

    logic [W-1:0]  rx_sr;
    logic [W-1:0]  gathered;
    logic [CW-1:0] pad;
    logic [W-1:0]  aligned;

    always_comb begin
        gathered = {rx_sr[W-2:0], sdi};
        pad      = CW'(W) - nbits;
        if (mode == WL_LOG) begin
            if (law == LAW_MU)                                              // R5
                aligned = {mulaw_expand(gathered[CODE_W-1:0]), {MULAW_PAD{1'b0}}};
            else                                                            // R4
                aligned = {alaw_expand(gathered[CODE_W-1:0]), {ALAW_PAD{1'b0}}};
        end else begin
            aligned = gathered << pad;                                      // R1
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rx_sr <= '0;
        else if (shift) rx_sr <= gathered;
    end

    always_ff @(posedge clk) begin
        if (rst)       rx_word <= '0;
        else if (last) rx_word <= aligned;
    end

    p_rx_on_last_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_word) |-> $past(last));

endmodule

// File: rtl/compand_serial_path.sv
module compand_serial_path
    import compand_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_wr,
    input  logic [15:0] tx_word,
    input  logic        stat_rd,
    input  logic        law_mu,
    input  logic [1:0]  wl_code,
    input  logic        bit_tick,
    input  logic        fsync,
    input  logic        sdi,
    output logic        sdo,
    output logic [15:0] rx_word,
    output logic        underrun
);

    wl_mode_e         mode;
    law_e             law;
    logic [CNT_W-1:0] nbits;
    logic             load;
    logic             shift;
    logic             deadline;
    logic             last;

    assign mode  = wl_mode_e'(wl_code);
    assign law   = law_e'(law_mu);
    assign nbits = bits_per_slot(mode);

    compand_slot_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .fsync    (fsync),
        .nbits    (nbits),
        .load     (load),
        .shift    (shift),
        .deadline (deadline),
        .last     (last)
    );

    compand_tx_path #(.W(WORD_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_wr    (tx_wr),
        .tx_word  (tx_word),
        .stat_rd  (stat_rd),
        .mode     (mode),
        .law      (law),
        .load     (load),
        .shift    (shift),
        .deadline (deadline),
        .sdo      (sdo),
        .underrun (underrun)
    );

    compand_rx_path #(.W(WORD_W), .CW(CNT_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .sdi     (sdi),
        .shift   (shift),
        .last    (last),
        .mode    (mode),
        .law     (law),
        .nbits   (nbits),
        .rx_word (rx_word)
    );

    p_reset_quiet_r11: assert property (@(posedge clk)
        $past(rst) |-> !underrun && !sdo && rx_word == 16'h0000);

endmodule

// File: tb/compand_serial_path_test.sv
module compand_serial_path_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_word = '0;
    logic        stat_rd = 1'b0;
    logic        law_mu = 1'b0;
    logic [1:0]  wl_code = 2'b00;
    logic        bit_tick = 1'b0;
    logic        fsync = 1'b0;
    logic        sdo;
    logic [15:0] rx_word;
    logic        underrun;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    compand_serial_path uut (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_word(tx_word),
        .stat_rd(stat_rd), .law_mu(law_mu), .wl_code(wl_code),
        .bit_tick(bit_tick), .fsync(fsync), .sdi(sdo),
        .sdo(sdo), .rx_word(rx_word), .underrun(underrun)
    );

    // {wl_code, law_mu, tx word, byte on line, expected rx word}, looped back
    localparam int NV = 11;
    localparam logic [42:0] VEC [NV] = '{
        {2'b01, 1'b0, 16'h0000, 8'hD5, 16'h0008},   // R2 R4 zero
        {2'b01, 1'b0, 16'h7FF8, 8'hAA, 16'h7E00},   // R2 R4 positive full scale
        {2'b01, 1'b0, 16'hFFF8, 8'h55, 16'hFFF8},   // R2 R4 minus one
        {2'b01, 1'b0, 16'h0400, 8'hE5, 16'h0420},   // R2 R4 segment 3
        {2'b01, 1'b1, 16'h0000, 8'hFF, 16'h0000},   // R3 R5 zero
        {2'b01, 1'b1, 16'h7FFC, 8'h80, 16'h7D7C},   // R3 R5 clipped positive
        {2'b01, 1'b1, 16'h8000, 8'h00, 16'h8284},   // R3 R5 most negative
        {2'b01, 1'b1, 16'h0190, 8'hDF, 16'h018C},   // R3 R5 segment 2
        {2'b00, 1'b0, 16'hA5C3, 8'hA5, 16'hA500},   // R1 8-bit
        {2'b10, 1'b0, 16'h9ABC, 8'h9A, 16'h9AB0},   // R1 12-bit
        {2'b11, 1'b1, 16'h1234, 8'h12, 16'h1234}    // R1 16-bit
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int slot_len(input logic [1:0] wl);
        return (wl == 2'b10) ? 12 : (wl == 2'b11) ? 16 : 8;
    endfunction

    task automatic pulse_wr(input logic [15:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_word = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pulse_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    // One slot: the fsync tick, then n bit ticks. Writes w after tick wr_at (-1 none).
    task automatic run_slot(input int wr_at, input logic [15:0] w,
                            output logic [15:0] line, output logic [16:0] urv);
        int n;
        n = slot_len(wl_code);
        line = '0;
        urv  = '0;
        for (int k = 0; k <= n; k++) begin
            @(negedge clk); bit_tick = 1'b1; fsync = (k == 0);
            @(negedge clk); bit_tick = 1'b0; fsync = 1'b0;
            if (k < n) line[15-k] = sdo;
            urv[k] = underrun;
            if (k == wr_at) pulse_wr(w);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] line;
        logic [16:0] urv;
        logic [42:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 sdo", {15'd0, sdo}, 16'h0000);
        chk("R11 rx_word", rx_word, 16'h0000);
        chk("R11 underrun", {15'd0, underrun}, 16'h0000);

        // Vector walk: priming slot captures, data slot sends and loops back
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            @(negedge clk); wl_code = v[42:41]; law_mu = v[40];
            run_slot(0, v[39:24], line, urv);
            run_slot(0, v[39:24], line, urv);
            chk($sformatf("R1/R2/R3/R6 line vec %0d", i), {8'h00, line[15:8]}, {8'h00, v[23:16]});
            chk($sformatf("R1/R4/R5 rx vec %0d", i), rx_word, v[15:0]);
            chk($sformatf("R7 no underrun vec %0d", i), {15'd0, underrun}, 16'h0000);
        end

        // Deadline: a write between ticks 6 and 7 is still on time (A-law, 8 bits)
        @(negedge clk); wl_code = 2'b01; law_mu = 1'b0;
        run_slot(0, 16'h0400, line, urv);
        run_slot(6, 16'h7FF8, line, urv);
        chk("R7 prior word sent", {8'h00, line[15:8]}, 16'h00E5);
        chk("R7 on-time write no underrun", {15'd0, underrun}, 16'h0000);
        run_slot(0, 16'h7FF8, line, urv);
        chk("R7 on-time word sent", {8'h00, line[15:8]}, 16'h00AA);

        // Late write after tick 7: flag rises exactly at tick 7
        run_slot(7, 16'h0000, line, urv);
        chk("R8 flag low before deadline", {15'd0, urv[6]}, 16'h0000);
        chk("R8 flag high at deadline", {15'd0, urv[7]}, 16'h0001);
        run_slot(-1, 16'h0000, line, urv);
        chk("R8 previous word resent", {8'h00, line[15:8]}, 16'h00AA);
        chk("R9 flag sticky", {15'd0, underrun}, 16'h0001);
        run_slot(-1, 16'h0000, line, urv);
        chk("R7 late word one slot later", {8'h00, line[15:8]}, 16'h00D5);

        // Clear sequence
        pulse_wr(16'h0000);
        @(negedge clk);
        chk("R9 write alone keeps flag", {15'd0, underrun}, 16'h0001);
        pulse_stat();
        @(negedge clk);
        chk("R9 status read alone keeps flag", {15'd0, underrun}, 16'h0001);
        pulse_wr(16'h0000);
        chk("R9 read then write clears", {15'd0, underrun}, 16'h0000);

        // Plain mode: no flag, word repeated
        @(negedge clk); wl_code = 2'b00;
        run_slot(0, 16'h3C00, line, urv);
        run_slot(-1, 16'h0000, line, urv);
        chk("R10 word sent", {8'h00, line[15:8]}, 16'h003C);
        chk("R10 no underrun", {15'd0, underrun}, 16'h0000);
        run_slot(-1, 16'h0000, line, urv);
        chk("R10 word resent", {8'h00, line[15:8]}, 16'h003C);
        chk("R10 still no underrun", {15'd0, underrun}, 16'h0000);

        summary();
        $finish;
    end

endmodule